// File: doc/BRIEF.md
# Fractional-Divider PWM Timer

This block is the time base behind a PWM channel. Count ticks come from one of two tick inputs, which are single-cycle enables in the system clock domain. A fractional divider thins them out. Its divisor has a 10-bit whole part and an 8-bit fraction. An 8-bit phase accumulator adds the fraction on every output tick. When that addition carries, the next tick interval is one input tick longer. Over time the mean spacing is therefore whole + fraction/256 input ticks. Each divided tick advances a counter. The counter wraps after 2^res counts and raises a one-cycle overflow pulse as it returns to zero.

Software drives a configuration word. The hold, clear and source-select fields take effect on the cycle after the write. The divisor and resolution are different: they are only captured into a staging register when the write also carries the apply strobe. Staged values move into use at the next counter wrap, so no period is cut short. While the clear field holds the counter at zero, staged values move into use immediately. The comparator and the output pin logic sit outside this block.

Top module: `pwm_frac_timer`

## Requirements
- R1: After synchronous reset the counter reads 0 and overflow is 0. The active divisor is 1.0 (whole 1, fraction 0), the active resolution is `DEF_RES`, and hold, clear and select are all 0.
- R2: With fraction 0 and whole part N ≥ 1, the counter advances once every N ticks of the selected source. Ticks of the selected source are counted only while the source is selected.
- R3: With fraction F, the phase accumulator starts at 0 and adds F on every divided tick. An addition that carries past 255 makes the following interval N+1 input ticks instead of N.
- R4: A whole part of 0 behaves exactly like a whole part of 1.
- R5: When a divided tick finds the counter at 2^res−1, the counter goes to 0. On that same edge `overflow` is 1 for exactly that one cycle. In every other cycle `overflow` is 0.
- R6: A resolution above `MAX_RES` (default 20) is treated as `MAX_RES`, and the counter never exceeds 2^MAX_RES−1.
- R7: While `cfg_pause` is in force, the counter holds its value and no overflow occurs. Once it is released, counting resumes from the held value.
- R8: While `cfg_clear` is in force, the counter and the divider phase are forced to 0 and overflow stays 0. Clear takes priority over a wrap on the same edge.
- R9: `cfg_src` = 0 selects `slow_tick` and `cfg_src` = 1 selects `ref_tick`. The unselected input has no effect.
- R10: A write with `cfg_update` = 0 leaves the divisor and resolution in use unchanged.
- R11: A write with `cfg_update` = 1 stages `cfg_div` (bits 17:8 whole, bits 7:0 fraction) and `cfg_res`. These become active on the edge of the next wrap, or on the first edge where clear is in force. A staging write on that same edge stays pending for the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Tick source 0 (one-cycle enable) |
| ref_tick | input | 1 | Tick source 1 (one-cycle enable) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_res | input | 5 | Resolution: counter wraps after 2^res counts |
| cfg_div | input | 18 | Divisor, bits 17:8 whole, bits 7:0 fraction/256 |
| cfg_pause | input | 1 | Hold counter and divider |
| cfg_clear | input | 1 | Force counter and divider phase to 0 |
| cfg_src | input | 1 | Tick source select |
| cfg_update | input | 1 | Stage divisor and resolution with this write |
| count | output | MAX_RES | Counter value |
| overflow | output | 1 | One-cycle pulse on wrap |

## Verification
The parameter hand-over happens on the same edge as a counter wrap. Two things can collide with that edge: a clear, and a fresh staging write. Directed sequences stage values mid-count with one-count resolution. This makes a wrap fall on most cycles, so a staging write lands on a wrap edge. Random stimulus also asserts clear at arbitrary points against running counts. A cycle-level reference model predicts the count and the overflow flag. It orders the hand-over exactly as R8 and R11 state: clear wins over the wrap, and a write on the hand-over edge stays pending. Any disagreement shows up as a count or overflow mismatch on the next cycle.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int RES_W  = 5;
  localparam int WHOLE_W = 10;
  localparam int FRAC_W = 8;
  localparam int DIV_W  = WHOLE_W + FRAC_W;

  typedef struct packed {
    logic [WHOLE_W-1:0] whole;
    logic [FRAC_W-1:0]  frac;
  } div_t;
endpackage

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
  import pwm_tmr_pkg::*;
#(
  parameter int DEF_RES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [RES_W-1:0] wr_res,
  input  div_t             wr_div,
  input  logic             wr_pause,
  input  logic             wr_clear,
  input  logic             wr_src,
  input  logic             wr_update,
  input  logic             wrap,
  output logic             pause_q,
  output logic             clear_q,
  output logic             src_q,
  output logic             pend_q,
  output logic [RES_W-1:0] act_res,
  output div_t             act_div
);
  logic [RES_W-1:0] stg_res;
  div_t             stg_div;
  logic             apply;

  assign apply = pend_q && (wrap || clear_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_q <= 1'b0;
      clear_q <= 1'b0;
      src_q   <= 1'b0;
      pend_q  <= 1'b0;
      stg_res <= RES_W'(DEF_RES);
      stg_div <= '{whole: WHOLE_W'(1), frac: '0};
      act_res <= RES_W'(DEF_RES);
      act_div <= '{whole: WHOLE_W'(1), frac: '0};
    end else begin
      if (apply) begin
        act_res <= stg_res;
        act_div <= stg_div;
        pend_q  <= 1'b0;
      end
      if (wr) begin
        pause_q <= wr_pause;
        clear_q <= wr_clear;
        src_q   <= wr_src;
        if (wr_update) begin
          stg_res <= wr_res;
          stg_div <= wr_div;
          pend_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_frac_divider.sv
module pwm_frac_divider
  import pwm_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic hold,
  input  logic in_tick,
  input  div_t div,
  output logic out_tick
);
  localparam int CW = WHOLE_W + 1;

  logic [CW-1:0]     gap_cnt;
  logic [FRAC_W-1:0] phase;
  logic              stretch;
  logic [CW-1:0]     whole_eff;
  logic [CW-1:0]     span;
  logic              hit;
  logic [FRAC_W:0]   phase_sum;

  assign whole_eff = (div.whole == '0) ? CW'(1) : {1'b0, div.whole};
  assign span      = whole_eff + CW'(stretch);
  assign hit       = (gap_cnt + CW'(1)) == span;
  assign phase_sum = {1'b0, phase} + {1'b0, div.frac};
  assign out_tick  = in_tick && !hold && !clear && hit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      gap_cnt <= '0;
      phase   <= '0;
      stretch <= 1'b0;
    end else if (in_tick && !hold) begin
      if (hit) begin
        gap_cnt <= '0;
        phase   <= phase_sum[FRAC_W-1:0];
        stretch <= phase_sum[FRAC_W];
      end else begin
        gap_cnt <= gap_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_wrap_counter.sv
module pwm_wrap_counter
  import pwm_tmr_pkg::*;
#(
  parameter int MAX_RES = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               tick,
  input  logic [RES_W-1:0]   res,
  output logic [MAX_RES-1:0] count,
  output logic               ovf,
  output logic               wrap
);
  localparam logic [RES_W-1:0] RES_CAP = RES_W'(MAX_RES);

  logic [RES_W-1:0]   res_eff;
  logic [MAX_RES-1:0] top;

  assign res_eff = (res > RES_CAP) ? RES_CAP : res;
  assign top     = ~({MAX_RES{1'b1}} << res_eff);
  assign wrap    = tick && (count == top);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wrap;
      if (wrap)      count <= '0;
      else if (tick) count <= count + MAX_RES'(1);
    end
  end
endmodule

// File: rtl/pwm_frac_timer.sv
module pwm_frac_timer
  import pwm_tmr_pkg::*;
#(
  parameter int MAX_RES = 20,
  parameter int DEF_RES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic               ref_tick,
  input  logic               cfg_wr,
  input  logic [4:0]         cfg_res,
  input  logic [17:0]        cfg_div,
  input  logic               cfg_pause,
  input  logic               cfg_clear,
  input  logic               cfg_src,
  input  logic               cfg_update,
  output logic [MAX_RES-1:0] count,
  output logic               overflow
);
  logic             pause_q, clear_q, src_q, pend_q;
  logic [RES_W-1:0] act_res;
  div_t             act_div;
  logic             sel_tick, div_tick, wrap;

  assign sel_tick = src_q ? ref_tick : slow_tick;

  pwm_cfg_stage #(.DEF_RES(DEF_RES)) u_stage (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_res(cfg_res), .wr_div(div_t'(cfg_div)),
    .wr_pause(cfg_pause), .wr_clear(cfg_clear), .wr_src(cfg_src),
    .wr_update(cfg_update), .wrap(wrap), .pause_q(pause_q), .clear_q(clear_q),
    .src_q(src_q), .pend_q(pend_q), .act_res(act_res), .act_div(act_div)
  );

  pwm_frac_divider u_div (
    .clk(clk), .rst(rst), .clear(clear_q), .hold(pause_q),
    .in_tick(sel_tick), .div(act_div), .out_tick(div_tick)
  );

  pwm_wrap_counter #(.MAX_RES(MAX_RES)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear_q), .tick(div_tick), .res(act_res),
    .count(count), .ovf(overflow), .wrap(wrap)
  );
endmodule

// File: rtl/pwm_frac_timer_chk.sv
module pwm_frac_timer_chk
  import pwm_tmr_pkg::*;
#(
  parameter int MAX_RES = 20
) (
  input logic               clk,
  input logic               rst,
  input logic [MAX_RES-1:0] count,
  input logic               overflow,
  input logic               pause_q,
  input logic               clear_q,
  input logic               pend_q,
  input logic [RES_W-1:0]   act_res,
  input div_t               act_div
);
  logic [RES_W-1:0]   res_c;
  logic [MAX_RES-1:0] top_c;
  assign res_c = (act_res > RES_W'(MAX_RES)) ? RES_W'(MAX_RES) : act_res;
  assign top_c = ~({MAX_RES{1'b1}} << res_c);

  // R5: overflow coincides with a zero count
  p_ovf_zero_r5: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count == '0));

  // R6: count stays inside the clamped range
  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    count <= top_c);

  // R7: hold freezes the counter
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pause_q && !clear_q) |=> ($stable(count) && !overflow));

  // R8: clear forces zero and no overflow
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clear_q |=> (count == '0 && !overflow));

  // R10: nothing pending means active parameters stay put
  p_no_pend_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> ($stable(act_div) && $stable(act_res)));
endmodule

bind pwm_frac_timer pwm_frac_timer_chk #(.MAX_RES(MAX_RES)) u_chk (
  .clk(clk), .rst(rst), .count(count), .overflow(overflow), .pause_q(pause_q),
  .clear_q(clear_q), .pend_q(pend_q), .act_res(act_res), .act_div(act_div)
);

// File: tb/pwm_frac_timer_bench.sv
module pwm_frac_timer_bench;
  localparam int MAXR = 10;
  localparam int DEFR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 0, ref_tick = 0, cfg_wr = 0;
  logic [4:0] cfg_res = 0;
  logic [17:0] cfg_div = 0;
  logic cfg_pause = 0, cfg_clear = 0, cfg_src = 0, cfg_update = 0;
  logic [MAXR-1:0] count;
  logic overflow;

  always #4 clk = ~clk;

  pwm_frac_timer #(.MAX_RES(MAXR), .DEF_RES(DEFR)) u_pwm_frac_timer (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .ref_tick(ref_tick),
    .cfg_wr(cfg_wr), .cfg_res(cfg_res), .cfg_div(cfg_div), .cfg_pause(cfg_pause),
    .cfg_clear(cfg_clear), .cfg_src(cfg_src), .cfg_update(cfg_update),
    .count(count), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_ovf, m_int, m_frac, m_res, s_int, s_frac, s_res;
  int m_pend, m_pause, m_clr, m_sel, m_acc, m_ext, m_gap;

  task automatic model_reset();
    m_cnt = 0; m_ovf = 0; m_int = 1; m_frac = 0; m_res = DEFR;
    s_int = 1; s_frac = 0; s_res = DEFR; m_pend = 0;
    m_pause = 0; m_clr = 0; m_sel = 0; m_acc = 0; m_ext = 0; m_gap = 0;
  endtask

  task automatic model_step();
    int ieff, re, top, s;
    bit it, dt, wr;
    ieff = (m_int == 0) ? 1 : m_int;
    re   = (m_res > MAXR) ? MAXR : m_res;
    top  = (1 << re) - 1;
    it   = m_sel ? ref_tick : slow_tick;
    dt = 0; wr = 0;
    if (m_clr != 0) begin
      m_gap = 0; m_acc = 0; m_ext = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      m_ovf = 0;
      if (it && m_pause == 0) begin
        if (m_gap + 1 == ieff + m_ext) begin
          dt = 1; m_gap = 0; s = m_acc + m_frac;
          m_ext = s >> 8; m_acc = s & 255;
        end else m_gap++;
      end
      if (dt) begin
        if (m_cnt == top) begin m_cnt = 0; m_ovf = 1; wr = 1; end
        else m_cnt++;
      end
    end
    if (m_pend != 0 && (wr || m_clr != 0)) begin
      m_int = s_int; m_frac = s_frac; m_res = s_res; m_pend = 0;
    end
    if (cfg_wr) begin
      m_pause = cfg_pause; m_clr = cfg_clear; m_sel = cfg_src;
      if (cfg_update) begin
        s_int = cfg_div[17:8]; s_frac = cfg_div[7:0]; s_res = cfg_res; m_pend = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (count !== MAXR'(m_cnt) || overflow !== (m_ovf != 0)) begin
      fails++;
      $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0d",
               tag, count, overflow, m_cnt, m_ovf);
    end
  endtask

  // mode: 0 none, 1 every cycle, 2 random
  function automatic logic pick(input int mode);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'($urandom % 2);
    return 1'b0;
  endfunction

  task automatic cycle(input string tag, input int smode, input int rmode);
    slow_tick = pick(smode);
    ref_tick  = pick(rmode);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    cfg_wr = 0;
  endtask

  task automatic run(input int n, input string tag, input int smode, input int rmode);
    for (int i = 0; i < n; i++) cycle(tag, smode, rmode);
  endtask

  task automatic cfg(input int res, input int whole, input int frac, input bit pz,
                     input bit clr, input bit sel, input bit upd, input string tag);
    cfg_wr = 1; cfg_res = 5'(res); cfg_div = {10'(whole), 8'(frac)};
    cfg_pause = pz; cfg_clear = clr; cfg_src = sel; cfg_update = upd;
    cycle(tag, 1, 0);
  endtask

  // apply through a clear window
  task automatic load(input int res, input int whole, input int frac, input bit sel,
                      input string tag);
    cfg(res, whole, frac, 0, 1, sel, 1, tag);
    run(2, tag, 1, 1);
    cfg(res, whole, frac, 0, 0, sel, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1");
    run(20, "R1", 1, 0);
    run(20, "R2", 2, 0);
    load(3, 4, 0, 0, "R8");
    run(60, "R2", 1, 0);
    run(40, "R2", 2, 2);
    load(2, 0, 0, 0, "R4");
    run(30, "R4", 2, 0);
    load(4, 2, 8'h60, 0, "R3");
    run(400, "R3", 1, 0);
    load(5, 1, 8'hFF, 0, "R3");
    run(300, "R3", 2, 0);
    load(0, 1, 0, 0, "R5");
    run(10, "R5", 1, 0);
    load(2, 1, 0, 0, "R5");
    run(30, "R5", 2, 0);
    load(31, 1, 0, 0, "R6");
    run(1100, "R6", 1, 0);
    load(10, 1, 0, 0, "R6");
    run(1100, "R6", 1, 0);
    load(4, 1, 0, 0, "R7");
    run(5, "R7", 1, 0);
    cfg(4, 1, 0, 1, 0, 0, 0, "R7");
    run(20, "R7", 1, 1);
    cfg(4, 1, 0, 0, 0, 0, 0, "R7");
    run(20, "R7", 1, 0);
    run(7, "R8", 1, 0);
    cfg(4, 1, 0, 0, 1, 0, 0, "R8");
    run(10, "R8", 1, 1);
    cfg(4, 1, 0, 0, 0, 0, 0, "R8");
    cfg(4, 1, 0, 0, 0, 1, 0, "R9");
    run(30, "R9", 1, 0);
    run(30, "R9", 0, 1);
    cfg(4, 1, 0, 0, 0, 0, 0, "R9");
    run(10, "R9", 0, 1);
    cfg(1, 3, 0, 0, 0, 0, 0, "R10");
    run(60, "R10", 1, 0);
    run(5, "R11", 1, 0);
    cfg(2, 2, 0, 0, 0, 0, 1, "R11");
    run(60, "R11", 1, 0);
    load(0, 1, 0, 0, "R11");
    for (int k = 0; k < 6; k++) begin
      cfg(k % 3, 1 + k % 2, 0, 0, 0, 0, 1, "R11");
      run(4, "R11", 1, 0);
    end
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 48 == 0) begin
        cfg_wr = 1;
        cfg_res = ($urandom % 8 == 0) ? 5'($urandom) : 5'($urandom % 6);
        cfg_div = {10'($urandom % 6), 8'($urandom)};
        cfg_pause = ($urandom % 8 == 0);
        cfg_clear = ($urandom % 10 == 0);
        cfg_src = 1'($urandom);
        cfg_update = 1'($urandom);
      end
      cycle("R3", 2, 2);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule